// File: doc/BRIEF.md
# Powered-Device Hot-Swap Sequencer

This block governs the input pass switch of a powered device fed over a network cable. It compares a digitized port voltage against two thresholds that together form a hysteresis band. Both the turn-on and the turn-off decision pass through a tick-based filter, so a short dip or spike on the cable cannot cycle the load.

Once the port is accepted, the switch closes with the low inrush current limit while the input capacitor charges. The block then selects the higher operational limit, and only with that limit in place does it enable the downstream DC-DC converter and release its soft-start. It watches the switch's drain-source voltage and a gate-high flag. It drops back to inrush whenever the drain-source voltage climbs too far.

An over-temperature flag is checked on every cycle and overrides every other transition. When that flag clears and the port is still valid, the block comes back up through inrush with the converter held off and soft-start discharged.

All controls are plain level signals. There is no data stream, so no valid/ready handshake is involved.

Top module: `pd_hotswap_seq`

## Requirements
- R1: The filtered port-valid state rises only after `vport > VON_TH` has held for exactly `PRESC*FILT` clock edges. The pass switch closes on the edge after that.
- R2: The filtered port-valid state falls only after `vport < VOFF_TH` has held for `PRESC*FILT` edges. A voltage inside the band `VOFF_TH..VON_TH` (VON_TH itself included) never changes the state.
- R3: Any cycle in which the raw comparison agrees with the current state reloads the filter. The full window must then pass again, so a glitch shorter than the window has no effect.
- R4: After turn-on the switch enters inrush mode: `pass_en=1`, `lim_oper=0` (0 selects inrush, 1 selects operational), `conv_en=0`, `ss_dis=1`.
- R5: Inrush moves to the operational limit on the next edge only when `vds < VDS_LO` and `gate_hi=1` are both true. In that state `conv_en=1` and `ss_dis=0`.
- R6: The operational limit holds while `vds < VDS_HI`. With `vds >= VDS_HI` the block returns to inrush on the next edge and clears `conv_en`.
- R7: When `otemp=1` is sampled, the next edge forces `pass_en=0`, `conv_en=0`, `lim_oper=0`, `ss_dis=1`. This takes priority over a promotion, a demotion or a turn-on in the same cycle.
- R8: On the edge that samples `otemp=0` after a thermal shutdown, the block re-enters inrush (R4 outputs) if the port is still valid. Otherwise it goes to the off state.
- R9: During and after reset, and in the off state, the outputs are `pass_en=0`, `conv_en=0`, `lim_oper=0`, `ss_dis=1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vport | input | VW | Digitized port voltage |
| vds | input | VDSW | Digitized pass-switch drain-source voltage |
| gate_hi | input | 1 | Pass-switch gate fully high (not limiting) |
| otemp | input | 1 | Over-temperature flag |
| lim_oper | output | 1 | Limit select: 0 inrush, 1 operational |
| pass_en | output | 1 | Pass-switch enable |
| conv_en | output | 1 | DC-DC converter enable |
| ss_dis | output | 1 | Soft-start discharge request |

## Verification
The collision of interest is the over-temperature override arriving in the same cycle as the inrush-to-operational promotion. The bench raises `otemp` on the same falling edge that presents `vds=0` with `gate_hi=1` to a switch in inrush. It judges the result one edge later: the outputs must show the shutdown pattern, with the operational limit never selected. A second collision clears the thermal flag after the filtered port state has dropped. This confirms that recovery consults the filter's output and returns to off, not to inrush.

// File: rtl/hs_pkg.sv
`timescale 1ns/1ps
package hs_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_INR   = 2'd1,
    ST_OPER  = 2'd2,
    ST_THERM = 2'd3
  } hs_state_t;

  typedef struct packed {
    logic pass_en;
    logic lim_oper;
    logic conv_en;
    logic ss_dis;
  } hs_ctl_t;
endpackage

// File: rtl/hs_uv_filter.sv
`timescale 1ns/1ps
module hs_uv_filter #(
  parameter int VW      = 8,
  parameter int VON_TH  = 38,
  parameter int VOFF_TH = 32,
  parameter int PRESC   = 50000,
  parameter int FILT    = 90
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [VW-1:0] vport,
  output logic          uv_ok
);
  localparam int PW = $clog2(PRESC > 1 ? PRESC : 2);
  localparam int FW = $clog2(FILT > 1 ? FILT : 2);
  localparam logic [VW-1:0] VON_V  = VW'(VON_TH);
  localparam logic [VW-1:0] VOFF_V = VW'(VOFF_TH);
  localparam logic [PW-1:0] PLAST  = PW'(PRESC - 1);
  localparam logic [FW-1:0] FLAST  = FW'(FILT - 1);

  logic          raw;
  logic          agree;
  logic          tick;
  logic [FW-1:0] cnt;

  // threshold depends on current state: hysteresis band
  assign raw   = uv_ok ? (vport >= VOFF_V) : (vport > VON_V);
  assign agree = (raw == uv_ok);

  generate
    if (PRESC > 1) begin : g_presc
      logic [PW-1:0] pre;
      always_ff @(posedge clk) begin
        if (rst || agree)     pre <= '0;
        else if (pre == PLAST) pre <= '0;
        else                  pre <= pre + 1'b1;
      end
      assign tick = !agree && (pre == PLAST);
    end else begin : g_nopresc
      assign tick = !agree;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      uv_ok <= 1'b0;
    end else if (agree) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt == FLAST) begin
        cnt   <= '0;
        uv_ok <= ~uv_ok;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R1 / R2: filtered state only flips while the raw compare disagreed
  assert_flip_needs_mismatch_R1: assert property (@(posedge clk) disable iff (rst)
    !$stable(uv_ok) |-> $past(!agree));

  // R3: an agreeing cycle empties the window, so no flip follows at once
  assert_reload_blocks_flip_R3: assert property (@(posedge clk) disable iff (rst)
    (agree && FILT > 1) |=> $stable(uv_ok));
endmodule

// File: rtl/hs_lim_fsm.sv
`timescale 1ns/1ps
module hs_lim_fsm
  import hs_pkg::*;
#(
  parameter int VDSW   = 8,
  parameter int VDS_LO = 1,
  parameter int VDS_HI = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            uv_ok,
  input  logic            otemp,
  input  logic [VDSW-1:0] vds,
  input  logic            gate_hi,
  output hs_ctl_t         ctl
);
  localparam logic [VDSW-1:0] LO_V = VDSW'(VDS_LO);
  localparam logic [VDSW-1:0] HI_V = VDSW'(VDS_HI);

  hs_state_t st, st_nx;
  logic      promote, demote;

  assign promote = (vds < LO_V) && gate_hi;
  assign demote  = (vds >= HI_V);

  always_comb begin
    st_nx = st;
    if (otemp) begin
      st_nx = ST_THERM;                 // highest priority, every cycle
    end else begin
      unique case (st)
        ST_OFF:   if (uv_ok) st_nx = ST_INR;
        ST_INR:   if (!uv_ok) st_nx = ST_OFF;
                  else if (promote) st_nx = ST_OPER;
        ST_OPER:  if (!uv_ok) st_nx = ST_OFF;
                  else if (demote) st_nx = ST_INR;
        ST_THERM: st_nx = uv_ok ? ST_INR : ST_OFF;
        default:  st_nx = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_OFF;
    else     st <= st_nx;
  end

  always_comb begin
    ctl = '{pass_en: 1'b0, lim_oper: 1'b0, conv_en: 1'b0, ss_dis: 1'b1};
    case (st)
      ST_INR:  ctl.pass_en = 1'b1;
      ST_OPER: ctl = '{pass_en: 1'b1, lim_oper: 1'b1, conv_en: 1'b1, ss_dis: 1'b0};
      default: ;
    endcase
  end

  assert_therm_off_R7: assert property (@(posedge clk) disable iff (rst)
    otemp |=> (!ctl.pass_en && !ctl.conv_en && !ctl.lim_oper && ctl.ss_dis));

  assert_promote_qual_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl.lim_oper) |-> $past((vds < LO_V) && gate_hi && !otemp));

  assert_demote_R6: assert property (@(posedge clk) disable iff (rst)
    (ctl.lim_oper && (vds >= HI_V) && !otemp) |=> !ctl.lim_oper);

  assert_uv_open_R2: assert property (@(posedge clk) disable iff (rst)
    !uv_ok |=> !ctl.pass_en);

  assert_recover_inrush_R8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_THERM && !otemp && uv_ok) |=> (ctl.pass_en && !ctl.lim_oper && ctl.ss_dis));
endmodule

// File: rtl/pd_hotswap_seq.sv
`timescale 1ns/1ps
module pd_hotswap_seq
  import hs_pkg::*;
#(
  parameter int VW      = 8,
  parameter int VDSW    = 8,
  parameter int VON_TH  = 38,
  parameter int VOFF_TH = 32,
  parameter int VDS_LO  = 1,
  parameter int VDS_HI  = 8,
  parameter int PRESC   = 50000,
  parameter int FILT    = 90
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [VW-1:0]   vport,
  input  logic [VDSW-1:0] vds,
  input  logic            gate_hi,
  input  logic            otemp,
  output logic            lim_oper,
  output logic            pass_en,
  output logic            conv_en,
  output logic            ss_dis
);
  logic    uv_ok;
  hs_ctl_t ctl;

  hs_uv_filter #(.VW(VW), .VON_TH(VON_TH), .VOFF_TH(VOFF_TH),
                 .PRESC(PRESC), .FILT(FILT)) u_filt (
    .clk(clk), .rst(rst), .vport(vport), .uv_ok(uv_ok));

  hs_lim_fsm #(.VDSW(VDSW), .VDS_LO(VDS_LO), .VDS_HI(VDS_HI)) u_fsm (
    .clk(clk), .rst(rst), .uv_ok(uv_ok), .otemp(otemp),
    .vds(vds), .gate_hi(gate_hi), .ctl(ctl));

  assign pass_en  = ctl.pass_en;
  assign lim_oper = ctl.lim_oper;
  assign conv_en  = ctl.conv_en;
  assign ss_dis   = ctl.ss_dis;

  // R9: converter never runs while the switch is open
  assert_conv_needs_pass_R9: assert property (@(posedge clk) disable iff (rst)
    conv_en |-> (pass_en && !ss_dis));
endmodule

// File: tb/pd_hotswap_seq_tb.sv
`timescale 1ns/1ps
module pd_hotswap_seq_tb;
  localparam int VON = 38, VOFF = 32, LO = 3, HI = 20, PR = 2, FI = 3;
  localparam int WIN = PR * FI;
  localparam logic [3:0] P_OFF = 4'b0001, P_INR = 4'b1001, P_OPER = 4'b1110;

  logic clk = 0, rst = 1, gate_hi = 0, otemp = 0;
  logic [7:0] vport = 0, vds = 8'hFF;
  logic lim_oper, pass_en, conv_en, ss_dis;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pd_hotswap_seq #(.VW(8), .VDSW(8), .VON_TH(VON), .VOFF_TH(VOFF),
    .VDS_LO(LO), .VDS_HI(HI), .PRESC(PR), .FILT(FI)) u_dut (
    .clk(clk), .rst(rst), .vport(vport), .vds(vds), .gate_hi(gate_hi),
    .otemp(otemp), .lim_oper(lim_oper), .pass_en(pass_en),
    .conv_en(conv_en), .ss_dis(ss_dis));

  task automatic chk(input string req, input logic [3:0] exp);
    logic [3:0] got;
    got = {pass_en, lim_oper, conv_en, ss_dis};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%b exp=%b t=%0t", req, got, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; vport = 0; vds = 8'hFF; gate_hi = 0; otemp = 0;
    edges(2);
    rst = 0;
  endtask

  task automatic power_up();
    vport = 8'd200;
    edges(WIN + 1);
  endtask

  initial begin
    do_reset();
    chk("R9", P_OFF);

    // R1: exact turn-on latency
    vport = 8'd39;
    edges(WIN);
    chk("R1", P_OFF);
    edges(1);
    chk("R1", P_INR);
    chk("R4", P_INR);

    // R1 sweep: turn-on iff vport > VON
    for (int v = 0; v < 256; v++) begin
      do_reset();
      vport = 8'(v);
      edges(WIN + 1);
      chk("R1", (v > VON) ? P_INR : P_OFF);
    end

    // R2 sweep: turn-off iff vport < VOFF
    for (int v = 0; v < 256; v++) begin
      do_reset();
      power_up();
      vport = 8'(v);
      edges(WIN + 1);
      chk("R2", (v >= VOFF) ? P_INR : P_OFF);
    end

    // R2 hysteresis: long dwell inside the band from both sides
    do_reset();
    vport = 8'(VON);
    edges(20);
    chk("R2", P_OFF);
    power_up();
    vport = 8'(VOFF);
    edges(20);
    chk("R2", P_INR);

    // R3: glitch reloads the window
    do_reset();
    vport = 8'd200;
    edges(WIN - 1);
    vport = 8'd0;
    edges(1);
    vport = 8'd200;
    edges(WIN);
    chk("R3", P_OFF);
    edges(1);
    chk("R3", P_INR);

    // R5 sweep: promotion only with low vds and gate high
    do_reset();
    power_up();
    for (int v = 0; v < 256; v++) begin
      for (int g = 0; g < 2; g++) begin
        vds = 8'(v); gate_hi = g[0];
        edges(1);
        chk("R5", (v < LO && g == 1) ? P_OPER : P_INR);
        if (pass_en && lim_oper) begin
          vds = 8'hFF;
          edges(1);
        end
      end
    end

    // R6 sweep: operational held while vds < HI
    vds = 0; gate_hi = 1;
    edges(1);
    chk("R6", P_OPER);
    for (int v = 0; v < 256; v++) begin
      vds = 8'(v);
      edges(1);
      chk("R6", (v < HI) ? P_OPER : P_INR);
      if (!lim_oper) begin
        vds = 0;
        edges(1);
      end
    end

    // R7: over-temperature in the same cycle as a promotion
    vds = 8'hFF;
    edges(1);
    chk("R6", P_INR);
    vds = 0; gate_hi = 1; otemp = 1;
    edges(1);
    chk("R7", P_OFF);
    edges(3);
    chk("R7", P_OFF);

    // R8: clear with port valid -> inrush, soft-start still discharged
    otemp = 0; vds = 8'hFF;
    edges(1);
    chk("R8", P_INR);

    // R7 from operational, then R8 with port gone
    vds = 0;
    edges(1);
    chk("R5", P_OPER);
    otemp = 1;
    edges(1);
    chk("R7", P_OFF);
    vport = 0;
    edges(WIN + 2);
    otemp = 0;
    edges(1);
    chk("R8", P_OFF);
    edges(3);
    chk("R8", P_OFF);

    // R7: over-temperature at turn-on blocks inrush
    do_reset();
    otemp = 1;
    power_up();
    chk("R7", P_OFF);
    otemp = 0;
    edges(1);
    chk("R8", P_INR);

    // R9: reset mid-operation
    vds = 0;
    edges(1);
    rst = 1;
    edges(1);
    chk("R9", P_OFF);
    rst = 0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule